// File: doc/BRIEF.md
# Set/Clear Interrupt Status Unit

This block keeps a 32-bit word of pending interrupt causes. Two hardware requesters, a compute-done source and a DMA-done source, each set a fixed bit of the word with a one-cycle request. Software can also set any bits by writing the raise offset, and it clears bits by writing the acknowledge offset. The same word is readable at the status offset.

A mode input selects how the pending state reaches the interrupt controller. In level mode, `irq_level` follows a set/clear rule. In message mode, every raise event emits a one-cycle notification pulse on `irq_pulse`, and acknowledges emit nothing. Turning the pulse into an actual message, and bridging to the bus, happen outside this block.

Top module: `irq_sc_unit`

## Requirements
- R1: During and after reset the status word reads 0, and `irq_level` and `irq_pulse` are low.
- R2: A write to offset 0x60 ORs the written value into the status word. The new value is visible one cycle later.
- R3: A write to offset 0x64 clears every status bit that is 1 in the written value and leaves the other bits unchanged.
- R4: With `rd_en` high and offset 0x24, `rdata` shows the current status word in the same cycle. Any other read returns 0.
- R5: `hw_raise[0]` (compute done) sets bit 0 (mask 0x00000001). `hw_raise[1]` (DMA done) sets bit 8 (mask 0x00000100).
- R6: When a set and a clear of the same bit fall in the same cycle, the clear is applied first and the set second, so the bit ends at 1.
- R7: In level mode (`msg_mode`=0), any raise event that leaves the status nonzero drives `irq_level` high on the next cycle. The line goes low on the next cycle only when an acknowledge leaves the status at zero. Otherwise it holds.
- R8: In message mode (`msg_mode`=1), each cycle holding a raise event that leaves the status nonzero gives exactly one cycle of `irq_pulse` on the next cycle. Acknowledges give no pulse, and `irq_level` holds its value.
- R9: A raise with value 0 while the status is 0, and with no hardware request in that cycle, leaves the status at 0, gives no pulse and does not change `irq_level`.
- R10: Writes to any offset other than 0x60 and 0x64 change neither the status nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| hw_raise | input | 2 | One-cycle requests from the hardware sources (bit 0 compute done, bit 1 DMA done) |
| msg_mode | input | 1 | 1 selects message mode, 0 selects level mode |
| irq_level | output | 1 | Level interrupt line |
| irq_pulse | output | 1 | One-cycle notification pulse |

## Verification
Random cycles mix raise writes, acknowledge writes, stray writes, reads and sparse hardware requests. The runs use both modes, so the bench can tell a raise that OR-merges from one that overwrites, and an acknowledge that clears selected bits from one that clears the whole word. Directed cases cover a zero raise on an empty word in both modes, which must stay silent. They also cover a hardware request colliding with an acknowledge of the same bit, which tells clear-then-set ordering from the reverse. Switching modes with bits pending shows that the level line stays frozen in message mode and that acknowledges never produce a pulse.

// File: rtl/irq_sc_pkg.sv
package irq_sc_pkg;

   // one-hot style decode of a single bus cycle
   typedef struct packed {
      logic raise_wr;
      logic ack_wr;
      logic stat_rd;
   } irq_sc_hit_t;

   localparam int unsigned IRQ_SC_DATA_W = 32;
   localparam int unsigned IRQ_SC_ADDR_W = 8;

endpackage

// File: rtl/irq_sc_decode.sv
module irq_sc_decode
   import irq_sc_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] OFF_STAT  = 8'h24,
   parameter logic [ADDR_W-1:0] OFF_RAISE = 8'h60,
   parameter logic [ADDR_W-1:0] OFF_ACK   = 8'h64
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output irq_sc_hit_t       hit,
   output logic [DATA_W-1:0] sw_set,
   output logic [DATA_W-1:0] sw_clr
);

   if (OFF_STAT == OFF_RAISE || OFF_STAT == OFF_ACK || OFF_RAISE == OFF_ACK) begin : g_bad_off
      $error("irq_sc_decode: register offsets must be distinct");
   end

   always_comb begin
      hit.raise_wr = wr_en && (addr == OFF_RAISE);
      hit.ack_wr   = wr_en && (addr == OFF_ACK);
      hit.stat_rd  = rd_en && (addr == OFF_STAT);
      sw_set       = hit.raise_wr ? wdata : '0;
      sw_clr       = hit.ack_wr   ? wdata : '0;
   end

endmodule

// File: rtl/irq_sc_hwmap.sv
module irq_sc_hwmap #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned N_SRC  = 2,
   parameter logic [N_SRC-1:0][DATA_W-1:0] SRC_MASK = {32'h0000_0100, 32'h0000_0001}
) (
   input  logic [N_SRC-1:0]  hw_raise,
   output logic [DATA_W-1:0] hw_set,
   output logic              hw_evt
);

   if (N_SRC < 1) begin : g_bad_n
      $error("irq_sc_hwmap: at least one hardware source is needed");
   end

   logic [N_SRC-1:0][DATA_W-1:0] masked;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (SRC_MASK[i] == '0) begin : g_bad_mask
         $error("irq_sc_hwmap: a source mask is zero");
      end
      assign masked[i] = hw_raise[i] ? SRC_MASK[i] : '0;
   end

   always_comb begin
      hw_set = '0;
      for (int unsigned k = 0; k < N_SRC; k++) begin
         hw_set = hw_set | masked[k];
      end
      hw_evt = |hw_raise;
   end

endmodule

// File: rtl/irq_sc_store.sv
module irq_sc_store #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_vec,
   input  logic [DATA_W-1:0] clr_vec,
   output logic [DATA_W-1:0] status_q,
   output logic [DATA_W-1:0] status_d
);

   if (DATA_W < 1) begin : g_bad_w
      $error("irq_sc_store: DATA_W must be positive");
   end

   // clear applied first, set second, so a simultaneous event survives
   assign status_d = (status_q & ~clr_vec) | set_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= status_d;
   end

   a_r2_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

   a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec != '0 && set_vec == '0) |=> ((status_q & $past(clr_vec)) == '0));

   a_r6_set_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_vec & set_vec) != '0) |=>
         ((status_q & $past(clr_vec & set_vec)) == $past(clr_vec & set_vec)));

endmodule

// File: rtl/irq_sc_signal.sv
module irq_sc_signal #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msg_mode,
   input  logic              raise_evt,
   input  logic              clr_evt,
   input  logic [DATA_W-1:0] status_d,
   output logic              irq_level,
   output logic              irq_pulse
);

   logic raise_hit;
   logic level_d;

   assign raise_hit = raise_evt && (status_d != '0);

   always_comb begin
      level_d = irq_level;
      if (!msg_mode) begin
         if (raise_hit)                           level_d = 1'b1;
         else if (clr_evt && (status_d == '0))    level_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_level <= 1'b0;
         irq_pulse <= 1'b0;
      end else begin
         irq_level <= level_d;
         irq_pulse <= msg_mode && raise_hit;
      end
   end

   a_r8_pulse_msg_only: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(msg_mode));

   a_r8_level_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(msg_mode) |-> $stable(irq_level));

endmodule

// File: rtl/irq_sc_unit.sv
module irq_sc_unit
   import irq_sc_pkg::*;
#(
   parameter int unsigned DATA_W = IRQ_SC_DATA_W,
   parameter int unsigned ADDR_W = IRQ_SC_ADDR_W,
   parameter int unsigned N_SRC  = 2,
   parameter logic [N_SRC-1:0][DATA_W-1:0] SRC_MASK = {32'h0000_0100, 32'h0000_0001},
   parameter logic [ADDR_W-1:0] OFF_STAT  = 8'h24,
   parameter logic [ADDR_W-1:0] OFF_RAISE = 8'h60,
   parameter logic [ADDR_W-1:0] OFF_ACK   = 8'h64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [N_SRC-1:0]  hw_raise,
   input  logic              msg_mode,
   output logic              irq_level,
   output logic              irq_pulse
);

   irq_sc_hit_t       hit;
   logic [DATA_W-1:0] sw_set, sw_clr, hw_set;
   logic              hw_evt;
   logic [DATA_W-1:0] status_q, status_d;

   irq_sc_decode #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .OFF_STAT(OFF_STAT), .OFF_RAISE(OFF_RAISE), .OFF_ACK(OFF_ACK)
   ) u_decode (
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .hit(hit), .sw_set(sw_set), .sw_clr(sw_clr)
   );

   irq_sc_hwmap #(
      .DATA_W(DATA_W), .N_SRC(N_SRC), .SRC_MASK(SRC_MASK)
   ) u_hwmap (
      .hw_raise(hw_raise), .hw_set(hw_set), .hw_evt(hw_evt)
   );

   irq_sc_store #(.DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .set_vec(sw_set | hw_set), .clr_vec(sw_clr),
      .status_q(status_q), .status_d(status_d)
   );

   irq_sc_signal #(.DATA_W(DATA_W)) u_signal (
      .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode),
      .raise_evt(hit.raise_wr || hw_evt), .clr_evt(hit.ack_wr),
      .status_d(status_d),
      .irq_level(irq_level), .irq_pulse(irq_pulse)
   );

   assign rdata = hit.stat_rd ? status_q : '0;

   a_r7_level_drop_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_level) |-> (status_q == '0));

   a_r9_zero_raise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q == '0 && wr_en && addr == OFF_RAISE && wdata == '0 && hw_raise == '0)
         |=> (!irq_pulse && $stable(irq_level) && status_q == '0));

endmodule

// File: tb/irq_sc_unit_tb.sv
module irq_sc_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, rd_en, msg_mode;
   logic [7:0]  addr;
   logic [31:0] wdata, rdata;
   logic [1:0]  hw_raise;
   logic        irq_level, irq_pulse;

   int n_chk = 0;
   int n_bad = 0;

   logic [31:0] m_stat;
   logic        m_lvl, m_pls;

   always #5 clk = ~clk;

   irq_sc_unit u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .hw_raise(hw_raise), .msg_mode(msg_mode),
      .irq_level(irq_level), .irq_pulse(irq_pulse)
   );

   function automatic logic [31:0] f_next(logic [31:0] st, logic wr, logic [7:0] a,
                                          logic [31:0] wd, logic [1:0] hw);
      logic [31:0] clr, set;
      clr = (wr && a == 8'h64) ? wd : 32'h0;
      set = (wr && a == 8'h60) ? wd : 32'h0;
      if (hw[0]) set = set | 32'h0000_0001;
      if (hw[1]) set = set | 32'h0000_0100;
      return (st & ~clr) | set;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one bus cycle; called at a falling edge, returns at the next falling edge
   task automatic cyc(string req, logic wr, logic rd, logic [7:0] a,
                      logic [31:0] wd, logic [1:0] hw, logic mm);
      logic [31:0] nx;
      logic        raise, hitv;
      wr_en = wr; rd_en = rd; addr = a; wdata = wd; hw_raise = hw; msg_mode = mm;
      #1;
      if (rd) chk({req, " R4 read"}, rdata, (a == 8'h24) ? m_stat : 32'h0);
      nx    = f_next(m_stat, wr, a, wd, hw);
      raise = (wr && a == 8'h60) || (hw != 2'b00);
      hitv  = raise && (nx != 32'h0);
      if (!mm) begin
         if (hitv) m_lvl = 1'b1;
         else if (wr && a == 8'h64 && nx == 32'h0) m_lvl = 1'b0;
      end
      m_pls  = mm && hitv;
      m_stat = nx;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; hw_raise = 2'b00;
      chk({req, " R7 level"}, {31'h0, irq_level}, {31'h0, m_lvl});
      chk({req, " R8 pulse"}, {31'h0, irq_pulse}, {31'h0, m_pls});
   endtask

   task automatic rd_stat(string req);
      rd_en = 1'b1; addr = 8'h24; #1;
      chk(req, rdata, m_stat);
      rd_en = 1'b0;
   endtask

   initial begin
      #(2_000_000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd24681));
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 8'h0; wdata = 32'h0;
      hw_raise = 2'b00; msg_mode = 1'b0;
      m_stat = 32'h0; m_lvl = 1'b0; m_pls = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 level in reset", {31'h0, irq_level}, 32'h0);
      chk("R1 pulse in reset", {31'h0, irq_pulse}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_stat("R1 status after reset");

      // R9: zero raise on empty word, both modes
      cyc("R9 lvl", 1'b1, 1'b0, 8'h60, 32'h0, 2'b00, 1'b0);
      cyc("R9 msg", 1'b1, 1'b0, 8'h60, 32'h0, 2'b00, 1'b1);
      rd_stat("R9 status stays zero");

      // R2/R3 directed
      cyc("R2 or-merge a", 1'b1, 1'b0, 8'h60, 32'h00F0_0000, 2'b00, 1'b0);
      cyc("R2 or-merge b", 1'b1, 1'b0, 8'h60, 32'h0000_000F, 2'b00, 1'b0);
      rd_stat("R2 merged word");
      cyc("R3 partial ack", 1'b1, 1'b0, 8'h64, 32'h0010_0003, 2'b00, 1'b0);
      rd_stat("R3 partial clear");
      // R10: stray offsets
      cyc("R10 stray", 1'b1, 1'b0, 8'h20, 32'hFFFF_FFFF, 2'b00, 1'b0);
      cyc("R10 stray2", 1'b1, 1'b0, 8'h24, 32'hFFFF_FFFF, 2'b00, 1'b0);
      rd_stat("R10 status unchanged");
      // R5 sources
      cyc("R5 compute", 1'b0, 1'b0, 8'h00, 32'h0, 2'b01, 1'b0);
      cyc("R5 dma", 1'b0, 1'b0, 8'h00, 32'h0, 2'b10, 1'b0);
      rd_stat("R5 source bits");
      // R6: ack of bit 8 collides with DMA done
      cyc("R6 collide", 1'b1, 1'b0, 8'h64, 32'hFFFF_FFFF, 2'b10, 1'b0);
      rd_stat("R6 bit8 survives");
      cyc("R7 drop", 1'b1, 1'b0, 8'h64, 32'hFFFF_FFFF, 2'b00, 1'b0);
      // R8: message mode raise and ack
      cyc("R8 raise", 1'b1, 1'b0, 8'h60, 32'h4, 2'b00, 1'b1);
      cyc("R8 raise again", 1'b0, 1'b0, 8'h0, 32'h0, 2'b01, 1'b1);
      cyc("R8 ack silent", 1'b1, 1'b0, 8'h64, 32'hFFFF_FFFF, 2'b00, 1'b1);

      for (int i = 0; i < 3000; i++) begin
         int unsigned op;
         logic [31:0] v;
         logic [1:0]  hw;
         logic        mm;
         logic [7:0]  a;
         op = $urandom_range(0, 9);
         v  = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
         if ($urandom_range(0, 7) == 0) v = 32'h0;
         hw = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
         mm = ((i / 300) % 2) == 1;
         a  = 8'($urandom_range(0, 255));
         case (op)
            0, 1, 2: cyc("R2 rnd", 1'b1, 1'b0, 8'h60, v, hw, mm);
            3, 4:    cyc("R3 rnd", 1'b1, 1'b0, 8'h64, ($urandom_range(0, 2) == 0) ? m_stat : v, hw, mm);
            5:       cyc("R10 rnd", 1'b1, 1'b0, (a == 8'h60 || a == 8'h64) ? 8'h10 : a, v, hw, mm);
            6, 7:    cyc("R4 rnd", 1'b0, 1'b1, 8'h24, 32'h0, hw, mm);
            8:       cyc("R4 rnd other", 1'b0, 1'b1, (a == 8'h24) ? 8'h28 : a, 32'h0, hw, mm);
            default: cyc("R5 rnd", 1'b0, 1'b0, 8'h00, 32'h0, hw, mm);
         endcase
      end

      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

endmodule